// File: doc/BRIEF.md
# I/O Port Permission Checker

This block rules on whether one I/O port access may go ahead when the task's privilege alone does not allow it. The caller gives it the base address and the limit of the current task state segment, a 16-bit port number and an access width, and starts it with a valid/ready handshake. The block then fetches the bitmap pointer, a 16-bit word that sits at a fixed offset inside the segment. It fetches one or two bitmap bytes and returns a single verdict: allow, or a general-protection fault.

Every byte-wide port owns one bit of the bitmap. A word or doubleword access needs the bits of all the ports it covers to be clear. Any bitmap byte that falls past the segment limit counts as a denial. Software can therefore switch the map off by pointing it past the limit, or shorten it by lowering the limit. Memory is reached through a simple read port that holds its request until it is acknowledged.

Top module: `iopm_gate`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` stays low from the next cycle until after `done`.
- R2: The first memory read of a request is a word read (`mem_word`=1) at `tss_base + 0x66`. Its data is little-endian: the byte at the lower address is `mem_rdata[7:0]`. The 16 bits read are the bitmap pointer.
- R3: If `tss_limit` is below 0x67, the request faults and no memory read is made.
- R4: The bit for port p is bit p%8 of the byte at segment offset (pointer + p/8). It is read as a byte read (`mem_word`=0) at `tss_base` plus that offset, with the data in `mem_rdata[7:0]`.
- R5: A bit value of 0 permits the port and a bit value of 1 denies it.
- R6: The `io_size` encoding is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes, and 3 also for 4 bytes. The access is allowed only if the bits of all covered ports p..p+n-1 are 0.
- R7: When the covered ports reach into the next bitmap byte, that byte is read at the next address after the first one, and its bits are checked too.
- R8: If the last bitmap byte needed lies at a segment offset above `tss_limit`, the request faults after the pointer read and no bitmap byte is read.
- R9: `done` is a one-cycle pulse per request. Exactly one of `allow` and `fault` is high with it, and both are low whenever `done` is low.
- R10: `mem_req` stays high, with `mem_addr` and `mem_word` unchanged, until `mem_ack`. Read data is taken in the cycle `mem_ack` is high.
- R11: If the first bitmap byte already denies the access, the second byte is not read.
- R12: Ports past 0xFFFF in a wide access at the top of the port space take their bits from the following bitmap byte; the port number does not wrap to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle, request can be taken |
| tss_base | input | 32 | Linear base address of the task state segment |
| tss_limit | input | 32 | Highest valid byte offset in the segment |
| io_port | input | 16 | First port of the access |
| io_size | input | 2 | Access width code (0:1, 1:2, 2/3:4 bytes) |
| mem_req | output | 1 | Memory read request |
| mem_word | output | 1 | 1: 16-bit read, 0: byte read |
| mem_addr | output | 32 | Read address |
| mem_ack | input | 1 | Read data valid, request complete |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | Verdict pulse |
| allow | output | 1 | Access permitted (with done) |
| fault | output | 1 | General-protection fault (with done) |

## Verification
A wrong pointer or wrong byte index shows on the next read. The bench records every read and compares the addresses with its own model, so the error appears within the same request. A wrong mask or a state that skips a byte changes the verdict at the following `done`, or changes the number of reads in that request. An FSM stuck outside idle keeps `req_ready` low. The per-request timeout catches this within a few hundred cycles, while the per-clock check catches a stray `allow` or `fault` in the very cycle it appears.

// File: rtl/iopm_pkg.sv
// Shared types for the I/O permission checker.
// Assumes: the width code follows the encoding given in the brief.
package iopm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_CHK,
        ST_LO,
        ST_HI,
        ST_FIN
    } iopm_state_e;

    // Number of byte ports covered by a width code.
    function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
        case (code)
            2'd0:    size_to_bytes = 3'd1;
            2'd1:    size_to_bytes = 3'd2;
            default: size_to_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/iopm_span.sv
// Works out which bitmap bytes an access covers, and the bits inside them.
// Assumes: at most 4 ports per access, so at most two bitmap bytes.
// Offsets are relative to the segment base and one bit wider than a port.
module iopm_span
    import iopm_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic [PORT_W-1:0] port,
    input  logic [1:0]        size_code,
    input  logic [PORT_W-1:0] map_ptr,
    output logic [PORT_W:0]   lo_rel,
    output logic [PORT_W:0]   hi_rel,
    output logic              spans,
    output logic [7:0]        mask_lo,
    output logic [7:0]        mask_hi
);
    localparam int REL_W = PORT_W + 1;

    logic [2:0]       nbytes;
    logic [REL_W-1:0] last_port;
    logic [15:0]      ones;
    logic [15:0]      window;

    // Last covered port (no wrap), byte offsets and the bit window.
    always_comb begin
        nbytes    = size_to_bytes(size_code);
        last_port = {1'b0, port} + {{(REL_W-3){1'b0}}, nbytes} - REL_W'(1);
        lo_rel    = {1'b0, map_ptr} + ({1'b0, port} >> 3);
        hi_rel    = {1'b0, map_ptr} + (last_port >> 3);
        spans     = (last_port[REL_W-1:3] != {1'b0, port[PORT_W-1:3]});
        ones      = (16'd1 << nbytes) - 16'd1;
        window    = ones << port[2:0];
        mask_lo   = window[7:0];
        mask_hi   = window[15:8];
    end

endmodule

// File: rtl/iopm_seq.sv
// Sequencer: takes a request, reads the bitmap pointer, checks the limit,
// reads one or two bitmap bytes and issues a single verdict.
// Assumes: memory holds mem_req until mem_ack; data is valid with mem_ack.
module iopm_seq
    import iopm_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          PORT_W  = 16,
    parameter logic [31:0] PTR_OFS = 32'h66
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] tss_base,
    input  logic [ADDR_W-1:0] tss_limit,
    input  logic [PORT_W-1:0] io_port,
    input  logic [1:0]        io_size,
    output logic              mem_req,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [PORT_W-1:0] mem_rdata,
    output logic [PORT_W-1:0] port_q,
    output logic [1:0]        size_q,
    output logic [PORT_W-1:0] ptr_q,
    input  logic [PORT_W:0]   lo_rel,
    input  logic [PORT_W:0]   hi_rel,
    input  logic              spans,
    input  logic [7:0]        mask_lo,
    input  logic [7:0]        mask_hi,
    output logic              done,
    output logic              allow,
    output logic              fault
);
    localparam int          REL_W   = PORT_W + 1;
    localparam int          PAD_W   = ADDR_W - REL_W;
    localparam logic [ADDR_W-1:0] PTR_A   = ADDR_W'(PTR_OFS);
    localparam logic [ADDR_W-1:0] PTR_END = ADDR_W'(PTR_OFS + 32'd1);

    iopm_state_e       state;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    logic              verdict_q;
    logic              take;
    logic [ADDR_W-1:0] hi_abs_rel;

    assign take       = req_valid && (state == ST_IDLE);
    assign hi_abs_rel = {{PAD_W{1'b0}}, hi_rel};

    // Handshake and verdict outputs decoded from the state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        done      = (state == ST_FIN);
        allow     = done && verdict_q;
        fault     = done && !verdict_q;
    end

    // Memory read request: pointer word, then low and high bitmap bytes.
    always_comb begin
        mem_req  = 1'b0;
        mem_word = 1'b0;
        mem_addr = '0;
        case (state)
            ST_PTR: begin
                mem_req  = 1'b1;
                mem_word = 1'b1;
                mem_addr = base_q + PTR_A;
            end
            ST_LO: begin
                mem_req  = 1'b1;
                mem_addr = base_q + {{PAD_W{1'b0}}, lo_rel};
            end
            ST_HI: begin
                mem_req  = 1'b1;
                mem_addr = base_q + {{PAD_W{1'b0}}, hi_rel};
            end
            default: ;
        endcase
    end

    // Request capture and state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            base_q    <= '0;
            limit_q   <= '0;
            port_q    <= '0;
            size_q    <= '0;
            ptr_q     <= '0;
            verdict_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        base_q    <= tss_base;
                        limit_q   <= tss_limit;
                        port_q    <= io_port;
                        size_q    <= io_size;
                        verdict_q <= 1'b0;
                        state     <= (tss_limit < PTR_END) ? ST_FIN : ST_PTR;
                    end
                end
                ST_PTR: begin
                    if (mem_ack) begin
                        ptr_q <= mem_rdata;
                        state <= ST_CHK;
                    end
                end
                ST_CHK: begin
                    state <= (hi_abs_rel > limit_q) ? ST_FIN : ST_LO;
                end
                ST_LO: begin
                    if (mem_ack) begin
                        if (|(mem_rdata[7:0] & mask_lo)) begin
                            state <= ST_FIN;
                        end else if (spans) begin
                            state <= ST_HI;
                        end else begin
                            verdict_q <= 1'b1;
                            state     <= ST_FIN;
                        end
                    end
                end
                ST_HI: begin
                    if (mem_ack) begin
                        verdict_q <= !(|(mem_rdata[7:0] & mask_hi));
                        state     <= ST_FIN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_SHORT_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (tss_limit < PTR_END)) |=> !mem_req); // R3
    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (allow != fault)); // R9
    AST_VERDICT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!allow && !fault)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_word))); // R10

endmodule

// File: rtl/iopm_gate.sv
// Top of the I/O permission checker: sequencer plus bitmap span decoder.
// Assumes: a 32-bit-class address space wider than the relative offsets.
module iopm_gate #(
    parameter int          ADDR_W  = 32,
    parameter int          PORT_W  = 16,
    parameter logic [31:0] PTR_OFS = 32'h66
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] tss_base,
    input  logic [ADDR_W-1:0] tss_limit,
    input  logic [PORT_W-1:0] io_port,
    input  logic [1:0]        io_size,
    output logic              mem_req,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [PORT_W-1:0] mem_rdata,
    output logic              done,
    output logic              allow,
    output logic              fault
);
    logic [PORT_W-1:0] port_q;
    logic [1:0]        size_q;
    logic [PORT_W-1:0] ptr_q;
    logic [PORT_W:0]   lo_rel;
    logic [PORT_W:0]   hi_rel;
    logic              spans;
    logic [7:0]        mask_lo;
    logic [7:0]        mask_hi;

    iopm_span #(.PORT_W(PORT_W)) u_span (
        .port      (port_q),
        .size_code (size_q),
        .map_ptr   (ptr_q),
        .lo_rel    (lo_rel),
        .hi_rel    (hi_rel),
        .spans     (spans),
        .mask_lo   (mask_lo),
        .mask_hi   (mask_hi)
    );

    iopm_seq #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .PTR_OFS(PTR_OFS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .tss_base  (tss_base),
        .tss_limit (tss_limit),
        .io_port   (io_port),
        .io_size   (io_size),
        .mem_req   (mem_req),
        .mem_word  (mem_word),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .port_q    (port_q),
        .size_q    (size_q),
        .ptr_q     (ptr_q),
        .lo_rel    (lo_rel),
        .hi_rel    (hi_rel),
        .spans     (spans),
        .mask_lo   (mask_lo),
        .mask_hi   (mask_hi),
        .done      (done),
        .allow     (allow),
        .fault     (fault)
    );

endmodule

// File: tb/iopm_gate_test.sv
module iopm_gate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] tss_base = '0;
    logic [31:0] tss_limit = '0;
    logic [15:0] io_port = '0;
    logic [1:0]  io_size = '0;
    logic        mem_req;
    logic        mem_word;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        done;
    logic        allow;
    logic        fault;

    int total = 0;
    int bad = 0;
    int wait_cnt = 0;
    bit in_run = 1'b0;

    logic [7:0] mem [int unsigned];
    int unsigned log_addr [$];
    bit          log_word [$];

    iopm_gate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .tss_base(tss_base), .tss_limit(tss_limit), .io_port(io_port), .io_size(io_size),
        .mem_req(mem_req), .mem_word(mem_word), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .allow(allow), .fault(fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rd(input int unsigned a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    // Memory model: acknowledges after a varying wait and logs every read.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_req && !mem_ack) begin
            if (wait_cnt >= (log_addr.size() % 3)) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem_word ? {rd(mem_addr + 1), rd(mem_addr)} : {8'h00, rd(mem_addr)};
                log_addr.push_back(mem_addr);
                log_word.push_back(mem_word);
                wait_cnt  <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Per-clock check of verdict outputs and busy hold-off.
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (!done && (allow || fault)) begin
                bad++;
                $display("FAIL R9: allow=%0b fault=%0b without done, expected 0 0", allow, fault);
            end else if (done && (allow == fault)) begin
                bad++;
                $display("FAIL R9: allow=%0b fault=%0b with done, expected exactly one", allow, fault);
            end else if (in_run && !done && req_ready) begin
                bad++;
                $display("FAIL R1: req_ready=%0b while busy, expected 0", req_ready);
            end
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: verdict and the list of expected reads.
    task automatic model(input int unsigned base, input int unsigned limit,
                         input int unsigned port, input int unsigned sz,
                         output bit ok, output int unsigned ra [$], output bit rw [$]);
        int unsigned n;
        int unsigned ptr;
        int unsigned first;
        int unsigned last;
        bit deny_lo;
        bit deny_hi;
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        ra.delete();
        rw.delete();
        ok = 1'b0;
        if (limit < 32'h67) return;
        ra.push_back(base + 32'h66);
        rw.push_back(1'b1);
        ptr   = {rd(base + 32'h67), rd(base + 32'h66)};
        first = ptr + port / 8;
        last  = ptr + (port + n - 1) / 8;
        if (last > limit) return;
        deny_lo = 1'b0;
        deny_hi = 1'b0;
        for (int i = 0; i < int'(n); i++) begin
            int unsigned q = port + i;
            bit b = rd(base + ptr + q / 8)[q % 8];
            if (ptr + q / 8 == first) deny_lo |= b;
            else deny_hi |= b;
        end
        ra.push_back(base + first);
        rw.push_back(1'b0);
        if (deny_lo) return;
        if (last != first) begin
            ra.push_back(base + last);
            rw.push_back(1'b0);
        end
        ok = !deny_hi;
    endtask

    task automatic run(input string tag, input int unsigned base, input int unsigned limit,
                       input int unsigned port, input int unsigned sz);
        bit          ok;
        int unsigned ra [$];
        bit          rw [$];
        int          cyc;
        model(base, limit, port, sz, ok, ra, rw);
        while (!req_ready) @(negedge clk);
        log_addr.delete();
        log_word.delete();
        tss_base  = base;
        tss_limit = limit;
        io_port   = port[15:0];
        io_size   = sz[1:0];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        in_run    = 1'b1;
        cyc = 0;
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        in_run = 1'b0;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL %s: no done after %0d cycles, expected a verdict", tag, cyc);
            return;
        end
        check({tag, " verdict"}, allow, ok);
        check({tag, " fault"}, fault, !ok);
        check({tag, " read count"}, log_addr.size(), ra.size());
        for (int i = 0; i < ra.size() && i < log_addr.size(); i++) begin
            check({tag, " read addr"}, log_addr[i], ra[i]);
            check({tag, " read kind"}, log_word[i], rw[i]);
        end
        @(negedge clk);
    endtask

    // Watchdog: an over-long run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mem[32'h1066] = 8'h80; mem[32'h1067] = 8'h00;
        mem[32'h1080] = 8'h00; mem[32'h1081] = 8'h10;
        mem[32'h1082] = 8'h80; mem[32'h1083] = 8'h01;
        mem[32'h1084] = 8'h01;
        mem[32'h4066] = 8'h00; mem[32'h4067] = 8'h01;
        mem[32'h60FF] = 8'h3F; mem[32'h6100] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ready", req_ready, 1);
        check("R9 reset done", done, 0);
        check("R10 reset mem_req", mem_req, 0);

        run("R2 R4 R5 single clear", 32'h1000, 32'h2000, 3, 0);
        run("R5 single denied", 32'h1000, 32'h2000, 12, 0);
        run("R6 word clear", 32'h1000, 32'h2000, 10, 1);
        run("R6 word one bit set", 32'h1000, 32'h2000, 11, 1);
        run("R6 dword denied", 32'h1000, 32'h2000, 9, 2);
        run("R6 dword clear", 32'h1000, 32'h2000, 8, 2);
        run("R6 code3 as dword", 32'h1000, 32'h2000, 20, 3);
        run("R6 word high bit", 32'h1000, 32'h2000, 22, 1);
        run("R7 span clear", 32'h1000, 32'h2000, 15, 1);
        run("R7 dword span clear", 32'h1000, 32'h2000, 6, 2);
        run("R7 span denied high", 32'h1000, 32'h2000, 29, 2);
        run("R11 early deny", 32'h1000, 32'h2000, 22, 2);
        run("R8 within limit", 32'h1000, 32'h81, 8, 0);
        run("R8 byte past limit", 32'h1000, 32'h81, 16, 0);
        run("R8 span past limit", 32'h1000, 32'h81, 15, 1);
        run("R8 map disabled", 32'h1000, 32'h67, 0, 0);
        run("R3 tiny segment", 32'h1000, 32'h66, 0, 0);
        run("R3 limit zero", 32'h1000, 32'h0, 5, 2);
        run("R12 top word", 32'h4000, 32'h3000, 32'hFFFE, 1);
        run("R12 top dword clear", 32'h4000, 32'h3000, 32'hFFFE, 2);
        mem[32'h6100] = 8'h02;
        run("R12 top dword denied", 32'h4000, 32'h3000, 32'hFFFE, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule